// File: doc/BRIEF.md
# Idle-Time Memory Scrubber

This block sweeps a configured window of memory in the background. It reads one word at a time and looks at the ECC status that the external decoder returns with the data. A word with a single flipped bit is written back with the corrected data. A word with an error that cannot be corrected is left alone, and its address is logged. A clean word is never rewritten. Scrubbing catches slowly accumulating soft errors before a second upset can land in the same word and make it unrecoverable.

Scrub accesses are opportunistic. A read or a write-back is issued only in a cycle where the host request input is low, so demand traffic is never delayed. An interval counter sets the pace. Each expiry grants permission for one scrub, and at most one permission is held while the host keeps the bus busy. Each completed scrub advances the pointer to the next word of the window, which runs from base to base+size-1. After the last word the pointer wraps back to base and a one-cycle pass-complete pulse is raised. With an idle host, a full pass of N words therefore takes about N times the interval.

Top module: `scrub_engine`

## Requirements
- R1: A scrub access (`mem_req` high, either a read or a write) is never presented in a cycle where `host_req` is high.
- R2: While the host is idle and the interval exceeds one scrub's duration, consecutive scrub reads start exactly `cfg_interval` cycles apart. An interval of 0 behaves like an interval of 1: the next read starts the cycle after the previous scrub completes.
- R3: Permission saved up while the host is busy is capped at one scrub. After a busy stretch longer than the interval, exactly one read is issued in the first cycle the host is idle, and no further read follows in the next two cycles.
- R4: Within one pass, each address from `cfg_base` to `cfg_base+cfg_size-1` is read once and no other address is read. `pass_done` pulses for one cycle after the last word completes, and the next read targets `cfg_base`.
- R5: When a read returns `mem_ecc_single`=1 and `mem_ecc_multi`=0, the block writes `mem_rdata` (already corrected) back to the same address, and `corr_count` increases by one.
- R6: A read that returns both status bits at 0 causes no write.
- R7: A read that returns `mem_ecc_multi`=1 counts as uncorrectable, even if `mem_ecc_single` is also set. It causes no write, increments `uncorr_count`, loads `last_uncorr_addr` with the address, and sets the sticky `uncorr_seen`.
- R8: If the host requests the address being scrubbed between that scrub's read and its write-back, the write-back is dropped. The same address is read again as the next scrub, and is corrected then if the host no longer collides.
- R9: `corr_count` and `uncorr_count` saturate at all ones.
- R10: When `cfg_size` is 0, no scrub access is made and `pass_done` stays low.
- R11: After reset, `mem_req`, `pass_done`, both counters, `uncorr_seen` and `last_uncorr_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request pending; a high level blocks scrub accesses |
| host_addr | input | ADDR_W | Word address of the host request, used for collision detection |
| cfg_base | input | ADDR_W | First word of the scrub window |
| cfg_size | input | ADDR_W+1 | Number of words in the window; 0 disables scrubbing |
| cfg_interval | input | IVL_W | Cycles between scrub permissions |
| mem_req | output | 1 | Scrub access valid this cycle |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | ADDR_W | Scrub word address |
| mem_wdata | output | DATA_W | Corrected data to write back |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read data after correction by the external decoder |
| mem_ecc_single | input | 1 | Response held a correctable single-bit error |
| mem_ecc_multi | input | 1 | Response held an uncorrectable error |
| pass_done | output | 1 | One-cycle pulse when the pointer wraps |
| corr_count | output | CNT_W | Saturating count of corrected words |
| uncorr_count | output | CNT_W | Saturating count of uncorrectable words |
| uncorr_seen | output | 1 | Sticky flag: an uncorrectable word was found |
| last_uncorr_addr | output | ADDR_W | Address of the most recent uncorrectable word |

## Verification
The main sweep scrubs an 8-word window seeded with a mix of clean, correctable and uncorrectable words. Per-address read and write tallies show whether the walk covers the window exactly once, and whether a write follows only the correctable reads and carries the corrected data. The same run measures the spacing between reads, which separates interval pacing from back-to-back issue. Two further windows are filled entirely with correctable or entirely with uncorrectable words, and they push the counters past their limit. A stretch of host traffic, a collision on the very word being scrubbed, a zero-size window and a one-word window cover permission capping, retry, disable and immediate wrap.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WB
  } scrub_st_e;

  typedef enum logic [1:0] {
    ECC_CLEAN,
    ECC_FIX,
    ECC_FATAL
  } ecc_kind_e;

  // Uncorrectable status outranks the correctable flag.
  function automatic ecc_kind_e classify(input logic single_err, input logic multi_err);
    if (multi_err)       return ECC_FATAL;
    else if (single_err) return ECC_FIX;
    else                 return ECC_CLEAN;
  endfunction

endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic             consume,
  output logic             grant
);

  logic [IVL_W-1:0] cnt;
  logic             tick;

  // Interval 0 is treated as 1: an expiry every cycle.
  function automatic logic [IVL_W-1:0] limit_of(input logic [IVL_W-1:0] ivl);
    return (ivl == '0) ? '0 : ivl - IVL_W'(1);
  endfunction

  assign tick = (cnt >= limit_of(cfg_interval));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      grant <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + IVL_W'(1);
      // Holds at most one saved permission; an expiry outranks consumption.
      if (tick)         grant <= 1'b1;
      else if (consume) grant <= 1'b0;
    end
  end

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_size,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              pass_done
);

  localparam int SZ_W = ADDR_W + 1;

  logic [ADDR_W-1:0] off;
  logic              at_last;

  // An offset beyond a shrunken window also counts as the end of the pass.
  function automatic logic is_last(input logic [ADDR_W-1:0] o, input logic [SZ_W-1:0] sz);
    return ({1'b0, o} + SZ_W'(1)) >= sz;
  endfunction

  assign at_last  = is_last(off, cfg_size);
  assign cur_addr = cfg_base + off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off       <= '0;
      pass_done <= 1'b0;
    end else begin
      if (advance) off <= at_last ? '0 : off + ADDR_W'(1);
      pass_done <= advance && at_last;
    end
  end

endmodule

// File: rtl/scrub_err_log.sv
module scrub_err_log #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_fix,
  input  logic              log_fatal,
  input  logic [ADDR_W-1:0] fatal_addr,
  output logic [CNT_W-1:0]  corr_cnt,
  output logic [CNT_W-1:0]  uncorr_cnt,
  output logic              uncorr_seen,
  output logic [ADDR_W-1:0] last_bad_addr
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_cnt      <= '0;
      uncorr_cnt    <= '0;
      uncorr_seen   <= 1'b0;
      last_bad_addr <= '0;
    end else begin
      if (log_fix) corr_cnt <= sat_inc(corr_cnt);
      if (log_fatal) begin
        uncorr_cnt    <= sat_inc(uncorr_cnt);
        uncorr_seen   <= 1'b1;
        last_bad_addr <= fatal_addr;
      end
    end
  end

endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int IVL_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_size,
  input  logic [IVL_W-1:0]  cfg_interval,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ecc_single,
  input  logic              mem_ecc_multi,
  output logic              pass_done,
  output logic [CNT_W-1:0]  corr_count,
  output logic [CNT_W-1:0]  uncorr_count,
  output logic              uncorr_seen,
  output logic [ADDR_W-1:0] last_uncorr_addr
);

  scrub_st_e         st, st_nxt;
  ecc_kind_e         kind;
  logic              grant;
  logic [ADDR_W-1:0] cur_addr;
  logic              hit_q;
  logic [DATA_W-1:0] wdata_q;

  // Named internal events, also observed by the checker.
  logic host_hit, collide;
  logic ev_start, ev_fix, ev_clean, ev_fatal, ev_wb, ev_abort, ev_advance;

  scrub_pacer #(.IVL_W(IVL_W)) u_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_interval (cfg_interval),
    .consume      (ev_advance),
    .grant        (grant)
  );

  scrub_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_base  (cfg_base),
    .cfg_size  (cfg_size),
    .advance   (ev_advance),
    .cur_addr  (cur_addr),
    .pass_done (pass_done)
  );

  scrub_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
    .clk           (clk),
    .rst_n         (rst_n),
    .log_fix       (ev_wb),
    .log_fatal     (ev_fatal),
    .fatal_addr    (cur_addr),
    .corr_cnt      (corr_count),
    .uncorr_cnt    (uncorr_count),
    .uncorr_seen   (uncorr_seen),
    .last_bad_addr (last_uncorr_addr)
  );

  always_comb begin
    kind       = classify(mem_ecc_single, mem_ecc_multi);
    host_hit   = host_req && (host_addr == cur_addr);
    collide    = hit_q || host_hit;
    ev_start   = (st == ST_IDLE) && grant && !host_req && (cfg_size != '0);
    ev_fix     = (st == ST_WAIT) && mem_rvalid && (kind == ECC_FIX);
    ev_clean   = (st == ST_WAIT) && mem_rvalid && (kind == ECC_CLEAN);
    ev_fatal   = (st == ST_WAIT) && mem_rvalid && (kind == ECC_FATAL);
    ev_wb      = (st == ST_WB) && !collide && !host_req;
    ev_abort   = (ev_fix && collide) || ((st == ST_WB) && collide);
    ev_advance = ev_clean || ev_fatal || ev_wb;
  end

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (ev_start) st_nxt = ST_WAIT;
      ST_WAIT: if (mem_rvalid) st_nxt = (ev_fix && !collide) ? ST_WB : ST_IDLE;
      ST_WB:   if (ev_wb || ev_abort) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      hit_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      st <= st_nxt;
      if (st == ST_WAIT || st == ST_WB) hit_q <= hit_q || host_hit;
      else                              hit_q <= 1'b0;
      if (ev_fix) wdata_q <= mem_rdata;
    end
  end

  assign mem_req   = ev_start || ev_wb;
  assign mem_we    = ev_wb;
  assign mem_addr  = cur_addr;
  assign mem_wdata = wdata_q;

endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [ADDR_W:0]   cfg_size,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pass_done,
  input logic [CNT_W-1:0]  corr_count,
  input logic [CNT_W-1:0]  uncorr_count,
  input logic              ev_fatal,
  input logic              ev_abort,
  input logic              grant
);

  logic [ADDR_W-1:0] chk_off;
  assign chk_off = mem_addr - cfg_base;

  AST_HOST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !host_req); // R1

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ({1'b0, chk_off} < cfg_size)); // R4

  AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done); // R4

  AST_WB_BUMPS_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !(&corr_count)) |=> corr_count == CNT_W'($past(corr_count) + 1'b1)); // R5

  AST_FATAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fatal |=> !(mem_req && mem_we)); // R7

  AST_ABORT_KEEPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> grant); // R8

  AST_CORR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (&corr_count) |=> (&corr_count)); // R9

  AST_UNCORR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (&uncorr_count) |=> (&uncorr_count)); // R9

  AST_SIZE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_size == '0) |-> !mem_req); // R10

endmodule

bind scrub_engine scrub_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_req     (host_req),
  .cfg_base     (cfg_base),
  .cfg_size     (cfg_size),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .pass_done    (pass_done),
  .corr_count   (corr_count),
  .uncorr_count (uncorr_count),
  .ev_fatal     (ev_fatal),
  .ev_abort     (ev_abort),
  .grant        (grant)
);

// File: tb/test_scrub_engine.sv
module test_scrub_engine;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          host_req = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW:0]   cfg_size = '0;
  logic [IW-1:0] cfg_interval = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ecc_single = 1'b0, mem_ecc_multi = 1'b0;
  logic          pass_done, uncorr_seen;
  logic [CW-1:0] corr_count, uncorr_count;
  logic [AW-1:0] last_uncorr_addr;

  scrub_engine #(.ADDR_W(AW), .DATA_W(DW), .IVL_W(IW), .CNT_W(CW)) i_scrub_engine (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_interval(cfg_interval),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_ecc_single(mem_ecc_single),
    .mem_ecc_multi(mem_ecc_multi), .pass_done(pass_done), .corr_count(corr_count),
    .uncorr_count(uncorr_count), .uncorr_seen(uncorr_seen), .last_uncorr_addr(last_uncorr_addr)
  );

  // Memory model and monitors: 0 = clean, 1 = correctable, 2 = uncorrectable.
  int            err_kind [256];
  int            rd_cnt [256];
  int            wr_cnt [256];
  logic [DW-1:0] wr_val [256];
  int            rd_cyc [64];
  logic [AW-1:0] rd_adr [64];
  int            cyc = 0, rd_n = 0, pass_n = 0, host_clash = 0;
  int            n_chk = 0, n_fail = 0;
  logic          p_v = 1'b0;
  logic [AW-1:0] p_a = '0;

  function automatic logic [DW-1:0] golden(input int a);
    logic [7:0] b;
    b = a[7:0];
    return {b, b, b, b} ^ 32'h5A3C_0F96;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      rd_cnt[mem_addr]++;
      if (rd_n < 64) begin
        rd_cyc[rd_n] = cyc;
        rd_adr[rd_n] = mem_addr;
      end
      rd_n++;
    end
    if (mem_req && mem_we) begin
      wr_cnt[mem_addr]++;
      wr_val[mem_addr] = mem_wdata;
    end
    if (mem_req && host_req) host_clash++;
    if (pass_done) pass_n++;
    p_v            <= mem_req && !mem_we && rst_n;
    p_a            <= mem_addr;
    mem_rvalid     <= p_v;
    mem_rdata      <= golden(int'(p_a));
    mem_ecc_single <= p_v && (err_kind[p_a] == 1);
    mem_ecc_multi  <= p_v && (err_kind[p_a] == 2);
    cyc++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_errs();
    for (int a = 0; a < 256; a++) err_kind[a] = 0;
  endtask

  task automatic do_reset(input int base, input int size, input int ivl, input bit busy);
    @(negedge clk);
    rst_n        = 1'b0;
    host_req     = busy;
    cfg_base     = AW'(base);
    cfg_size     = (AW+1)'(size);
    cfg_interval = IW'(ivl);
    repeat (3) @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      rd_cnt[a] = 0;
      wr_cnt[a] = 0;
      wr_val[a] = '0;
    end
    rd_n   = 0;
    pass_n = 0;
    rst_n  = 1'b1;
  endtask

  task automatic wait_pass(input int n, input int limit, input string req);
    int g = 0;
    while (pass_n < n && g < limit) begin
      @(negedge clk);
      g++;
    end
    check(req, longint'(pass_n >= n), 1);
  endtask

  task automatic wait_reads(input int n, input int limit, input string req);
    int g = 0;
    while (rd_n < n && g < limit) begin
      @(negedge clk);
      g++;
    end
    check(req, longint'(rd_n >= n), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int other, wsum, rel, g;
    clear_errs();

    // R11: reset state
    do_reset(16, 8, 6, 1'b0);
    check("R11 mem_req", mem_req, 0);
    check("R11 pass_done", pass_done, 0);
    check("R11 corr_count", corr_count, 0);
    check("R11 uncorr_count", uncorr_count, 0);
    check("R11 uncorr_seen", uncorr_seen, 0);
    check("R11 last_uncorr_addr", last_uncorr_addr, 0);

    // Main sweep: window 16..23, interval 6, mixed error pattern
    clear_errs();
    err_kind[18] = 1;
    err_kind[20] = 2;
    err_kind[21] = 1;
    do_reset(16, 8, 6, 1'b0);
    wait_pass(1, 400, "R4 pass completes");
    for (int a = 16; a < 24; a++) check("R4 one read per word", rd_cnt[a], 1);
    other = 0;
    for (int a = 0; a < 256; a++) if (a < 16 || a > 23) other += rd_cnt[a];
    check("R4 no read outside window", other, 0);
    check("R5 write at 18", wr_cnt[18], 1);
    check("R5 data at 18", wr_val[18], golden(18));
    check("R5 write at 21", wr_cnt[21], 1);
    check("R5 data at 21", wr_val[21], golden(21));
    check("R5 corr_count", corr_count, 2);
    check("R6 clean words not written",
          wr_cnt[16] + wr_cnt[17] + wr_cnt[19] + wr_cnt[22] + wr_cnt[23], 0);
    check("R7 no write at 20", wr_cnt[20], 0);
    check("R7 uncorr_count", uncorr_count, 1);
    check("R7 last_uncorr_addr", last_uncorr_addr, 20);
    check("R7 uncorr_seen", uncorr_seen, 1);
    for (int i = 1; i < 8; i++) check("R2 read spacing", rd_cyc[i] - rd_cyc[i-1], 6);
    wait_reads(9, 100, "R4 read after wrap");
    check("R4 wrap returns to base", rd_adr[8], 16);
    check("R2 spacing across wrap", rd_cyc[8] - rd_cyc[7], 6);
    check("R1 no access during host request", host_clash, 0);

    // R2: interval 0 and 1 both issue back to back after completion
    clear_errs();
    do_reset(0, 4, 0, 1'b0);
    wait_reads(4, 100, "R2 reads with interval 0");
    check("R2 interval 0 spacing", rd_cyc[3] - rd_cyc[2], 3);
    do_reset(0, 4, 1, 1'b0);
    wait_reads(4, 100, "R2 reads with interval 1");
    check("R2 interval 1 spacing", rd_cyc[3] - rd_cyc[2], 3);

    // R3 and R1: long host busy stretch, then release
    do_reset(0, 4, 6, 1'b1);
    repeat (40) @(negedge clk);
    check("R1 no read while host busy", rd_n, 0);
    rel = cyc;
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 single saved read", rd_n, 1);
    check("R3 read in release cycle", rd_cyc[0], rel);

    // R8: host collides with word 41 while its scrub read is outstanding
    clear_errs();
    err_kind[41] = 1;
    do_reset(40, 4, 8, 1'b0);
    host_addr = 8'd41;
    g = 0;
    while (!(mem_req && !mem_we && mem_addr == 8'd41) && g < 500) begin
      @(negedge clk);
      g++;
    end
    check("R8 scrub read of 41 seen", longint'(g < 500), 1);
    @(negedge clk);
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    wait_pass(1, 400, "R8 pass completes");
    check("R8 word read twice", rd_cnt[41], 2);
    check("R8 single write after retry", wr_cnt[41], 1);
    check("R8 retried data", wr_val[41], golden(41));
    check("R8 corr_count", corr_count, 1);

    // R9: saturation of both counters
    clear_errs();
    for (int a = 100; a < 120; a++) err_kind[a] = 1;
    do_reset(100, 20, 1, 1'b0);
    wait_pass(1, 1000, "R9 correctable pass");
    check("R9 corr_count saturates", corr_count, 15);
    check("R9 uncorr_count untouched", uncorr_count, 0);
    wsum = 0;
    for (int a = 100; a < 120; a++) wsum += wr_cnt[a];
    check("R5 every correctable word written", wsum, 20);
    for (int a = 100; a < 120; a++) err_kind[a] = 2;
    do_reset(100, 20, 1, 1'b0);
    wait_pass(1, 1000, "R9 uncorrectable pass");
    check("R9 uncorr_count saturates", uncorr_count, 15);
    check("R7 last address of pass", last_uncorr_addr, 119);
    check("R9 corr_count untouched", corr_count, 0);
    wsum = 0;
    for (int a = 100; a < 120; a++) wsum += wr_cnt[a];
    check("R7 no writes on uncorrectable", wsum, 0);

    // R10: empty window
    clear_errs();
    do_reset(0, 0, 1, 1'b0);
    repeat (60) @(negedge clk);
    check("R10 no reads", rd_n, 0);
    check("R10 no pass pulse", pass_n, 0);

    // R4: one-word window wraps every scrub
    do_reset(200, 1, 1, 1'b0);
    wait_pass(2, 200, "R4 one-word passes");
    check("R4 one-word window reads only base", rd_cnt[200], rd_n);
    check("R4 one-word window reread", longint'(rd_n >= 2), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule